// File: doc/BRIEF.md
# Audio/Video Switch Status Change Interrupt Monitor

This block watches the control and activity signals of a dual-connector audio/video switch. It also raises one interrupt request to a microcontroller whenever a watched status changes. Four kinds of input arrive at it:

- two three-level slow-switch signals, one for the TV port and one for the VCR port, each as a 2-bit code from external comparators;
- the VCR fast-switch logic input;
- a set of video activity-detect flags;
- single-cycle pulses from the load-sense logic.

The slow-switch codes pass through a run-length filter before they are latched. A voltage that sweeps through a threshold band therefore cannot raise a false event.

Each event source owns a sticky change flag. A per-source enable mask selects which flags may pull the interrupt line, which is active low and models an open-drain pin. The flags are recorded whatever the mask holds. The microcontroller reads the latched levels, the activity word and the flag word through a small read port. Reading the flag word acknowledges, and so clears, every flag. All inputs are assumed to be synchronous to `clk`.

Top module: `avsw_status_irq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), both latched slow-switch levels are low (00), the latched fast-switch bit and activity word are 0, all change flags are clear and irq_n is 1 (released).
- R2: Slow-switch codes mean 00 = low, 01 = medium, 10 = high. A code of 11 is invalid: it leaves the latched level unchanged and neither breaks nor extends a run of valid samples.
- R3: A new slow-switch level is latched only at the edge that sees the STABLE_N-th consecutive valid sample of that code. A shorter run followed by another code changes nothing.
- R4: Latching a new TV level sets flag bit 0, and latching a new VCR level sets flag bit 1, at that same edge.
- R5: A change of vcr_fsw in either direction sets flag bit 2 at the first edge that samples the new value. The sampled value is readable at status address 0, bit 4.
- R6: A change of any bit of act_in sets flag bit 3 at the first edge that samples it. The sampled activity word is readable at status address 1, bits NACT-1:0.
- R7: A one-cycle high on any bit of load_chg sets flag bit 4. The flag stays set after the pulse ends.
- R8: irq_n is 0 exactly when some flag bit is set whose irq_mask bit is 1. Flags are recorded whatever the mask holds.
- R9: rd_data shows, unused bits zero:
  - at address 0, the TV level in bits 1:0, the VCR level in bits 3:2 and the fast-switch bit in bit 4;
  - at address 1, the activity word;
  - at address 2, the flag word;
  - at address 3, zero.
- R10: rd_en with rd_addr = 2 clears all flags at that edge, except that a flag set in the same cycle stays set. rd_en at any other address clears nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tv_sw_code | input | 2 | TV port slow-switch comparator code |
| vcr_sw_code | input | 2 | VCR port slow-switch comparator code |
| vcr_fsw | input | 1 | VCR fast-switch logic input |
| act_in | input | NACT | Video activity-detect flags |
| load_chg | input | NLOAD | Load-sense change pulses |
| irq_mask | input | 5 | Per-source interrupt enable (bit order as flag word) |
| rd_en | input | 1 | Read strobe (acknowledge when at address 2) |
| rd_addr | input | AW | Status read address |
| rd_data | output | DW | Status read data |
| irq_n | output | 1 | Interrupt request, 0 = pull low, 1 = released |

## Verification
The bench drives every ordered pair of distinct slow-switch levels on both ports and sweeps run lengths from one to STABLE_N+1. A filter whose count is off by one would latch a cycle early or late, or would latch a run that is too short. Runs split by the invalid code 11 check that the code neither resets nor advances the count. A design that restarted the run would latch late, and one that counted the code would latch early. The bench also sweeps every mask against two flag patterns, which catches a wrong bit in the mask gating. It then checks that a read-clear coinciding with a new event keeps the new flag, and that reads of other addresses do not acknowledge.

// File: rtl/avsw_irq_pkg.sv
// Shared constants for the status change interrupt monitor.
// Assumes: five event sources, two-bit status address space.
package avsw_irq_pkg;

    localparam int NSRC = 5;

    // Event source positions inside the flag word and the mask.
    localparam int SRC_TV_LVL  = 0;
    localparam int SRC_VCR_LVL = 1;
    localparam int SRC_FSW     = 2;
    localparam int SRC_ACT     = 3;
    localparam int SRC_LOAD    = 4;

    // Three-level slow-switch code, plus the one unused pattern.
    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_MID  = 2'b01,
        LVL_HIGH = 2'b10,
        LVL_BAD  = 2'b11
    } lvl_e;

    // Status read addresses.
    localparam int ADDR_SW   = 0;
    localparam int ADDR_ACT  = 1;
    localparam int ADDR_FLAG = 2;

endpackage

// File: rtl/avsw_lvl_filter.sv
// Run-length filter for one slow-switch comparator code.
// A valid code is latched once it has been seen on STABLE_N consecutive
// valid samples; code 11 is skipped without touching the run.
// Assumes: smp is synchronous to clk, STABLE_N >= 1.
module avsw_lvl_filter
    import avsw_irq_pkg::*;
#(
    parameter int STABLE_N = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] smp,
    output logic [1:0] lvl,
    output logic       chg
);

    localparam int CW = $clog2(STABLE_N + 1);

    logic [1:0]    cand;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nxt;
    logic          valid;

    // Next run length and the latch decision for this sample.
    always_comb begin
        valid = (smp != LVL_BAD);
        if (smp == cand)
            cnt_nxt = (cnt == CW'(STABLE_N)) ? cnt : cnt + CW'(1);
        else
            cnt_nxt = CW'(1);
        chg = valid && (cnt_nxt == CW'(STABLE_N)) && (smp != lvl);
    end

    // Track the candidate run and latch the level when the run completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand <= LVL_LOW;
            cnt  <= '0;
            lvl  <= LVL_LOW;
        end else if (valid) begin
            cand <= smp;
            cnt  <= cnt_nxt;
            if (chg)
                lvl <= smp;
        end
    end

    // R2: the invalid code never moves the latched level.
    a_r2_bad_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (smp == LVL_BAD) |=> (lvl == $past(lvl)));

    // R2: the latched level is always one of the three legal codes.
    a_r2_level_legal: assert property (@(posedge clk) disable iff (!rst_n)
        lvl != LVL_BAD);

    // R3: a reported change leaves the sampled code as the new level.
    a_r3_latch_takes_sample: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> (lvl == $past(smp)));

endmodule

// File: rtl/avsw_change_flags.sv
// Sticky per-source change flags with a mask-gated, active-low interrupt.
// A set request always wins over a clear in the same cycle.
// Assumes: set_i bits are single-cycle or level requests, clr_i is one cycle.
module avsw_change_flags #(
    parameter int NSRC = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic            clr_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] flags_o,
    output logic            irq_n_o
);

    // Hold, clear on acknowledge, and set on new events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_o <= '0;
        else
            flags_o <= (flags_o & ~{NSRC{clr_i}}) | set_i;
    end

    // Open-drain request: pull low while an enabled flag is pending.
    always_comb begin
        irq_n_o = ~|(flags_o & mask_i);
    end

    // R10: a flag set in a cycle is present afterwards, even with a clear.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    // R10: an acknowledge with no new event leaves no flag.
    a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (set_i == '0)) |=> (flags_o == '0));

    // R8: with no event, no clear and a steady mask, the request holds.
    a_r8_irq_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && (set_i == '0)) |=> (!$stable(mask_i) || $stable(irq_n_o)));

endmodule

// File: rtl/avsw_status_mux.sv
// Status read multiplexer: level word, activity word, flag word.
// Assumes: DW is wide enough for each word; unused bits read as zero.
module avsw_status_mux
    import avsw_irq_pkg::*;
#(
    parameter int NACT = 4,
    parameter int DW   = 8,
    parameter int AW   = 2
) (
    input  logic [AW-1:0]   addr,
    input  logic [1:0]      tv_lvl,
    input  logic [1:0]      vcr_lvl,
    input  logic            fsw,
    input  logic [NACT-1:0] act,
    input  logic [NSRC-1:0] flags,
    output logic [DW-1:0]   data
);

    // Select the addressed status word, zero-extended.
    always_comb begin
        data = '0;
        case (addr)
            AW'(ADDR_SW):   data[4:0]      = {fsw, vcr_lvl, tv_lvl};
            AW'(ADDR_ACT):  data[NACT-1:0] = act;
            AW'(ADDR_FLAG): data[NSRC-1:0] = flags;
            default:        data = '0;
        endcase
    end

endmodule

// File: rtl/avsw_status_irq.sv
// Status change interrupt monitor for a dual-port audio/video switch.
// Filters both slow-switch codes, samples fast-switch and activity inputs,
// folds all change events into sticky flags and a masked active-low request.
// Assumes: all inputs synchronous to clk; load_chg bits are pulses.
module avsw_status_irq
    import avsw_irq_pkg::*;
#(
    parameter int STABLE_N = 4,
    parameter int NACT     = 4,
    parameter int NLOAD    = 2,
    parameter int DW       = 8,
    parameter int AW       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       tv_sw_code,
    input  logic [1:0]       vcr_sw_code,
    input  logic             vcr_fsw,
    input  logic [NACT-1:0]  act_in,
    input  logic [NLOAD-1:0] load_chg,
    input  logic [NSRC-1:0]  irq_mask,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             irq_n
);

    localparam int NPORT = 2;

    logic [1:0]      code_arr [NPORT];
    logic [1:0]      lvl_arr  [NPORT];
    logic [NPORT-1:0] chg_arr;
    logic            fsw_q;
    logic [NACT-1:0] act_q;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] flags;
    logic            ack;

    // Port order of the slow-switch filters: TV first, then VCR.
    always_comb begin
        code_arr[0] = tv_sw_code;
        code_arr[1] = vcr_sw_code;
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        avsw_lvl_filter #(.STABLE_N(STABLE_N)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .smp   (code_arr[g]),
            .lvl   (lvl_arr[g]),
            .chg   (chg_arr[g])
        );
    end

    // Sample the fast-switch and activity inputs for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsw_q <= 1'b0;
            act_q <= '0;
        end else begin
            fsw_q <= vcr_fsw;
            act_q <= act_in;
        end
    end

    // Gather one event per source and decode the acknowledge read.
    always_comb begin
        set_vec              = '0;
        set_vec[SRC_TV_LVL]  = chg_arr[0];
        set_vec[SRC_VCR_LVL] = chg_arr[1];
        set_vec[SRC_FSW]     = vcr_fsw ^ fsw_q;
        set_vec[SRC_ACT]     = |(act_in ^ act_q);
        set_vec[SRC_LOAD]    = |load_chg;
        ack                  = rd_en && (rd_addr == AW'(ADDR_FLAG));
    end

    avsw_change_flags #(.NSRC(NSRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_vec),
        .clr_i   (ack),
        .mask_i  (irq_mask),
        .flags_o (flags),
        .irq_n_o (irq_n)
    );

    avsw_status_mux #(.NACT(NACT), .DW(DW), .AW(AW)) u_mux (
        .addr    (rd_addr),
        .tv_lvl  (lvl_arr[0]),
        .vcr_lvl (lvl_arr[1]),
        .fsw     (fsw_q),
        .act     (act_q),
        .flags   (flags),
        .data    (rd_data)
    );

    // R8: the request is only ever driven while some source is enabled.
    a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (|irq_mask));

    // R5: a fast-switch transition leaves its flag set.
    a_r5_fsw_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (vcr_fsw != fsw_q) |=> flags[SRC_FSW]);

    // R7: a load-sense pulse leaves its flag set.
    a_r7_load_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_chg) |=> flags[SRC_LOAD]);

endmodule

// File: tb/avsw_status_irq_test.sv
`timescale 1ns/1ps
module avsw_status_irq_test;

    localparam int N     = 4;
    localparam int NACT  = 4;
    localparam int NLOAD = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       tv_sw_code = 2'b00;
    logic [1:0]       vcr_sw_code = 2'b00;
    logic             vcr_fsw = 1'b0;
    logic [NACT-1:0]  act_in = '0;
    logic [NLOAD-1:0] load_chg = '0;
    logic [4:0]       irq_mask = '1;
    logic             rd_en = 1'b0;
    logic [1:0]       rd_addr = 2'd0;
    logic [7:0]       rd_data;
    logic             irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    avsw_status_irq #(.STABLE_N(N), .NACT(NACT), .NLOAD(NLOAD), .DW(8), .AW(2)) uut (
        .clk(clk), .rst_n(rst_n), .tv_sw_code(tv_sw_code), .vcr_sw_code(vcr_sw_code),
        .vcr_fsw(vcr_fsw), .act_in(act_in), .load_chg(load_chg), .irq_mask(irq_mask),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic peek(input int a, output logic [7:0] d);
        rd_addr = 2'(a);
        #0.5;
        d = rd_data;
    endtask

    task automatic ack_flags();
        rd_addr = 2'd2;
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic set_code(input int p, input logic [1:0] c);
        if (p == 0) tv_sw_code = c;
        else        vcr_sw_code = c;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [1:0] cur [2];
        logic [1:0] seq [6];
        seq[0] = 2'b01; seq[1] = 2'b10; seq[2] = 2'b00;
        seq[3] = 2'b10; seq[4] = 2'b01; seq[5] = 2'b00;
        cur[0] = 2'b00; cur[1] = 2'b00;

        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        peek(0, d); check("R1 level word", d, 0);
        peek(1, d); check("R1 activity word", d, 0);
        peek(2, d); check("R1 flag word", d, 0);
        check("R1 irq released", irq_n, 1);

        // R2 R3 R4 R8 R9: all level transitions on both ports
        for (int p = 0; p < 2; p++) begin
            for (int k = 0; k < 6; k++) begin
                ack_flags();
                set_code(p, seq[k]);
                repeat (N - 1) tick();
                peek(0, d);
                check("R3 level before full run", (d >> (2 * p)) & 3, cur[p]);
                peek(2, d); check("R3 no flag before full run", d, 0);
                tick();
                peek(0, d);
                check("R2 R9 level after full run", (d >> (2 * p)) & 3, seq[k]);
                peek(2, d); check("R4 level flag bit", d, 1 << p);
                check("R8 irq asserted", irq_n, 0);
                cur[p] = seq[k];
            end
        end

        // R3: run-length sweep on the TV port, from low to medium
        for (int len = 1; len <= N + 1; len++) begin
            ack_flags();
            tv_sw_code = 2'b01;
            repeat (len) tick();
            peek(0, d);
            check("R3 level after run", d & 3, (len >= N) ? 1 : 0);
            tv_sw_code = 2'b00;
            repeat (N) tick();
            peek(0, d); check("R3 level restored", d & 3, 0);
            peek(2, d); check("R3 flag after run", d, (len >= N) ? 1 : 0);
        end

        // R2: invalid code neither breaks nor extends the run
        ack_flags();
        tv_sw_code = 2'b10; repeat (2) tick();
        tv_sw_code = 2'b11; repeat (3) tick();
        peek(0, d); check("R2 invalid keeps level", d & 3, 0);
        tv_sw_code = 2'b10; tick();
        peek(0, d); check("R2 invalid not counted", d & 3, 0);
        tick();
        peek(0, d); check("R2 run resumes across invalid", d & 3, 2);
        tv_sw_code = 2'b11; repeat (10) tick();
        peek(0, d); check("R2 long invalid keeps level", d & 3, 2);
        tv_sw_code = 2'b00; repeat (N) tick();
        peek(0, d); check("R2 back to low", d & 3, 0);

        // R5: fast-switch edges
        ack_flags();
        vcr_fsw = 1'b1; tick();
        peek(2, d); check("R5 rise sets flag", d, 4);
        peek(0, d); check("R5 sampled fast switch", (d >> 4) & 1, 1);
        ack_flags();
        repeat (5) tick();
        peek(2, d); check("R5 steady input no flag", d, 0);
        vcr_fsw = 1'b0; tick();
        peek(2, d); check("R5 fall sets flag", d, 4);

        // R6: each activity bit
        for (int i = 0; i < NACT; i++) begin
            ack_flags();
            act_in = NACT'(1 << i); tick();
            peek(2, d); check("R6 activity rise flag", d, 8);
            peek(1, d); check("R6 activity word", d, 1 << i);
            ack_flags();
            act_in = '0; tick();
            peek(2, d); check("R6 activity fall flag", d, 8);
        end

        // R7: each load pulse
        for (int i = 0; i < NLOAD; i++) begin
            ack_flags();
            load_chg = NLOAD'(1 << i); tick();
            load_chg = '0;
            peek(2, d); check("R7 load flag", d, 16);
            tick();
            peek(2, d); check("R7 load flag sticky", d, 16);
        end

        // R8: all sources at once, then mask sweep
        ack_flags();
        irq_mask = '0;
        tv_sw_code = 2'b01; vcr_sw_code = 2'b01;
        repeat (N - 1) tick();
        vcr_fsw = 1'b1; act_in = 4'b0001; load_chg = 2'b01;
        tick();
        load_chg = '0;
        peek(2, d); check("R8 all flags recorded with mask off", d, 31);
        check("R8 mask off releases irq", irq_n, 1);
        for (int m = 0; m < 32; m++) begin
            irq_mask = 5'(m);
            #0.5;
            check("R8 mask sweep all flags", irq_n, (m == 0) ? 1 : 0);
        end
        ack_flags();
        load_chg = 2'b10; tick(); load_chg = '0;
        for (int m = 0; m < 32; m++) begin
            irq_mask = 5'(m);
            #0.5;
            check("R8 mask sweep load flag", irq_n, ((m >> 4) & 1) ? 0 : 1);
        end

        // R9 R10: reads elsewhere do not acknowledge
        rd_en = 1'b1;
        rd_addr = 2'd0; tick();
        rd_addr = 2'd1; tick();
        rd_addr = 2'd3; tick();
        rd_en = 1'b0;
        peek(2, d); check("R10 other reads keep flags", d, 16);
        peek(3, d); check("R9 address 3 reads zero", d, 0);

        // R10: set in the acknowledge cycle wins
        rd_addr = 2'd2; rd_en = 1'b1; load_chg = 2'b01;
        tick();
        rd_en = 1'b0; load_chg = '0;
        peek(2, d); check("R10 set beats clear", d, 16);
        ack_flags();
        peek(2, d); check("R10 acknowledge clears", d, 0);
        check("R10 irq released after ack", irq_n, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule